// File: doc/BRIEF.md
# Two-Column Shaper Eligibility Selector

This block is the shaper stage of a slotted fair-queuing scheduler. Waiting head-of-line segments sit in storage that is addressed by their start time: each of `NCOL` columns holds up to `DEPTH` entries, and each entry carries a finish time and a session number. An entry becomes eligible once its start time has been reached by the system virtual time. Because every time is an integer that counts fixed-length slots, the start time maps directly to a column.

Once per slot the surrounding logic pulses `slot_start`. With that pulse it supplies two column addresses: the current virtual time (column A) and the start time of the segment that was just served (column B). The block searches column A and then column B. In each column it picks the entry with the smallest finish time. It offers each winner on a valid/ready output and removes it from storage when the transfer is accepted. It then raises `slot_done` for one cycle. At most two entries leave in one slot.

New entries are written through a separate valid/ready insert port. This port is open only between sequences.

Top module: `shaper_elig_sel`

## Requirements
- R1: After reset `out_valid` and `slot_done` are 0, `ins_ready` is 1 for every column, and a slot run at once makes no transfer.
- R2: `ins_ready` is 1 only while no slot sequence is running and the addressed column holds fewer than `DEPTH` entries. An insert is accepted on a clock edge with `ins_valid` and `ins_ready` both high.
- R3: The first offer of a slot comes from column `vt_col`. It is the entry with the smallest finish time. If two entries have the same finish time, the one with the smaller session number wins.
- R4: The second offer comes from column `sent_col` and is chosen by the same rule as R3. It appears only after the column-A offer has been accepted, or after column A was found empty.
- R5: A slot makes at most two transfers. `slot_done` is high for exactly one cycle after the column-B step.
- R6: When `sent_col` equals `vt_col`, only the column-A transfer is made in that slot.
- R7: An empty column produces no offer, and the sequence moves on to its next step.
- R8: An accepted entry is removed from its column and frees its place, so it is never offered again.
- R9: While `out_valid` is 1 and `out_ready` is 0, the offer and all its fields stay unchanged.
- R10: A `slot_start` pulse that arrives while a sequence is running is ignored.
- R11: `out_from_b` is 0 for an offer from column A and 1 for an offer from column B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_start | input | 1 | Starts one slot sequence |
| vt_col | input | CW | Virtual-time column, sampled with slot_start |
| sent_col | input | CW | Start-time column of the last served segment, sampled with slot_start |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert can be accepted |
| ins_col | input | CW | Start-time column of the new entry |
| ins_fin | input | FW | Finish time of the new entry |
| ins_sid | input | SW | Session number of the new entry |
| out_valid | output | 1 | Eligible entry offered |
| out_ready | input | 1 | Scheduler queue accepts the offer |
| out_fin | output | FW | Finish time of the offered entry |
| out_sid | output | SW | Session number of the offered entry |
| out_from_b | output | 1 | Offer comes from column B |
| slot_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions check, on every cycle, the rules that hold regardless of the data:
- an offer holds steady under backpressure;
- `slot_done` is a single-cycle pulse with no offer alongside it;
- inserts are closed while an offer is up;
- a column-B offer never appears when both columns match;
- no slot makes a third transfer.

Only the bench scenarios can show that the right entry wins inside a column, including the tie on finish time. The same holds for entries really leaving storage and freeing a full column, and for a stray `slot_start` having no effect. A vector table covers several slot patterns over a preloaded storage state: two hits, a shared column, empty columns and a full column. Directed tests then cover backpressure and the stray pulse.

// File: rtl/shaper_elig_sel.sv
module shaper_elig_sel #(
  parameter int NCOL  = 8,
  parameter int DEPTH = 4,
  parameter int FW    = 8,
  parameter int SW    = 4,
  localparam int CW   = $clog2(NCOL),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_start,
  input  logic [CW-1:0] vt_col,
  input  logic [CW-1:0] sent_col,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [CW-1:0] ins_col,
  input  logic [FW-1:0] ins_fin,
  input  logic [SW-1:0] ins_sid,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [FW-1:0] out_fin,
  output logic [SW-1:0] out_sid,
  output logic          out_from_b,
  output logic          slot_done
);

  typedef enum logic [1:0] {S_IDLE, S_A, S_B, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] va_q, vb_q;
  logic [DEPTH-1:0] vld   [NCOL];
  logic [FW-1:0]    fin_m [NCOL][DEPTH];
  logic [SW-1:0]    sid_m [NCOL][DEPTH];

  logic [CW-1:0]    cur;
  logic             hit;
  logic [IW-1:0]    best_i;
  logic [FW+SW-1:0] best_key;
  logic             has_free;
  logic [IW-1:0]    free_i;
  logic             skip_b;
  logic             fire, ins_fire;

  assign cur        = (st == S_B) ? vb_q : va_q;
  assign skip_b     = (vb_q == va_q);
  assign out_from_b = (st == S_B);
  assign out_valid  = hit && ((st == S_A) || (st == S_B && !skip_b));
  assign out_fin    = best_key[FW+SW-1:SW];
  assign out_sid    = best_key[SW-1:0];
  assign slot_done  = (st == S_DONE);
  assign ins_ready  = (st == S_IDLE) && has_free;
  assign fire       = out_valid && out_ready;
  assign ins_fire   = ins_valid && ins_ready;

  always_comb begin
    hit      = 1'b0;
    best_i   = '0;
    best_key = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[cur][i] && (!hit || {fin_m[cur][i], sid_m[cur][i]} < best_key)) begin
        hit      = 1'b1;
        best_i   = IW'(i);
        best_key = {fin_m[cur][i], sid_m[cur][i]};
      end
    end
  end

  always_comb begin
    has_free = 1'b0;
    free_i   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[ins_col][i]) begin
        has_free = 1'b1;
        free_i   = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      va_q <= '0;
      vb_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (slot_start) begin
          va_q <= vt_col;
          vb_q <= sent_col;
          st   <= S_A;
        end
        S_A:    if (!hit || out_ready) st <= S_B;
        S_B:    if (!hit || skip_b || out_ready) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOL; c++) vld[c] <= '0;
    end else if (fire) begin
      vld[cur][best_i] <= 1'b0;
    end else if (ins_fire) begin
      vld[ins_col][free_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      fin_m[ins_col][free_i] <= ins_fin;
      sid_m[ins_col][free_i] <= ins_sid;
    end
  end

  logic [1:0] xcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             xcnt <= '0;
    else if (st == S_IDLE)  xcnt <= '0;
    else if (fire)          xcnt <= xcnt + 2'd1;
  end

  a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_fin) && $stable(out_sid) && $stable(out_from_b));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |=> !slot_done);
  a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |-> !out_valid);
  a_r5_max_two: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> xcnt < 2'd2);
  a_r2_no_ins_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !ins_ready);
  a_r6_same_col: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_from_b |-> vb_q != va_q);

endmodule

// File: tb/sim_shaper_elig_sel.sv
module sim_shaper_elig_sel;
  localparam int NCOL = 8, DEPTH = 4, FW = 8, SW = 4, CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_start = 1'b0;
  logic [CW-1:0] vt_col = '0, sent_col = '0, ins_col = '0;
  logic ins_valid = 1'b0, out_ready = 1'b0;
  logic [FW-1:0] ins_fin = '0;
  logic [SW-1:0] ins_sid = '0;
  logic ins_ready, out_valid, out_from_b, slot_done;
  logic [FW-1:0] out_fin;
  logic [SW-1:0] out_sid;

  always #10 clk = ~clk;

  shaper_elig_sel #(.NCOL(NCOL), .DEPTH(DEPTH), .FW(FW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .vt_col(vt_col), .sent_col(sent_col),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_col(ins_col), .ins_fin(ins_fin),
    .ins_sid(ins_sid), .out_valid(out_valid), .out_ready(out_ready), .out_fin(out_fin),
    .out_sid(out_sid), .out_from_b(out_from_b), .slot_done(slot_done));

  int nchk = 0, nfail = 0;
  bit ended = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic insert(input int col, input int fin, input int sid, input int exp_rdy);
    @(negedge clk);
    ins_col = CW'(col); ins_fin = FW'(fin); ins_sid = SW'(sid); ins_valid = 1'b1;
    #1 chk("R2 ins_ready", int'(ins_ready), exp_rdy);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  int rcnt;
  int rfin [2], rsid [2], rsrc [2];

  task automatic run_slot(input int a, input int b);
    int guard;
    rcnt = 0;
    @(negedge clk);
    vt_col = CW'(a); sent_col = CW'(b); slot_start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
    guard = 0;
    while (!slot_done && guard < 20) begin
      if (out_valid) begin
        if (rcnt < 2) begin
          rfin[rcnt] = int'(out_fin); rsid[rcnt] = int'(out_sid); rsrc[rcnt] = int'(out_from_b);
        end
        rcnt++;
      end
      @(negedge clk);
      guard++;
    end
    chk("R5 slot_done reached", int'(slot_done), 1);
    @(negedge clk);
    chk("R5 slot_done one cycle", int'(slot_done), 0);
  endtask

  // {a, b, count, fin0, sid0, src0, fin1, sid1, src1}
  localparam logic [33:0] VEC [6] = '{
    {3'd1, 3'd3, 2'd2, 8'd15, 4'd0, 1'b0, 8'd30, 4'd3, 1'b1},
    {3'd1, 3'd1, 2'd1, 8'd15, 4'd2, 1'b0, 8'd0,  4'd0, 1'b0},
    {3'd3, 3'd5, 2'd1, 8'd12, 4'd5, 1'b1, 8'd0,  4'd0, 1'b0},
    {3'd5, 3'd1, 2'd2, 8'd40, 4'd4, 1'b0, 8'd20, 4'd1, 1'b1},
    {3'd1, 3'd5, 2'd0, 8'd0,  4'd0, 1'b0, 8'd0,  4'd0, 1'b0},
    {3'd2, 3'd2, 2'd1, 8'd50, 4'd6, 1'b0, 8'd0,  4'd0, 1'b0}
  };

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    if (!ended) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid reset", int'(out_valid), 0);
    chk("R1 slot_done reset", int'(slot_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCOL; c++) begin
      ins_col = CW'(c);
      #1 chk("R1 ins_ready empty column", int'(ins_ready), 1);
    end
    run_slot(0, 7);
    chk("R1 R7 empty slot count", rcnt, 0);

    insert(1, 20, 1, 1); insert(1, 15, 2, 1); insert(1, 15, 0, 1);
    insert(3, 30, 3, 1);
    insert(5, 40, 4, 1); insert(5, 12, 5, 1);
    insert(2, 50, 6, 1); insert(2, 51, 7, 1); insert(2, 52, 8, 1); insert(2, 53, 9, 1);
    insert(2, 54, 10, 0);

    for (int v = 0; v < 6; v++) begin
      logic [33:0] e;
      e = VEC[v];
      if (v == 5) begin
        ins_col = 3'd2;
        #1 chk("R2 full column not ready", int'(ins_ready), 0);
      end
      run_slot(int'(e[33:31]), int'(e[30:28]));
      chk("R5 R6 R7 transfer count", rcnt, int'(e[27:26]));
      if (e[27:26] >= 2'd1) begin
        chk("R3 first fin", rfin[0], int'(e[25:18]));
        chk("R3 first sid", rsid[0], int'(e[17:14]));
        chk("R11 first source", rsrc[0], int'(e[13]));
      end
      if (e[27:26] == 2'd2) begin
        chk("R4 second fin", rfin[1], int'(e[12:5]));
        chk("R4 second sid", rsid[1], int'(e[4:1]));
        chk("R11 second source", rsrc[1], int'(e[0]));
      end
    end
    ins_col = 3'd2;
    #1 chk("R8 freed place in column", int'(ins_ready), 1);

    insert(4, 9, 1, 1); insert(6, 7, 2, 1);
    @(negedge clk);
    vt_col = 3'd4; sent_col = 3'd6; slot_start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    slot_start = 1'b0;
    chk("R9 offer up", int'(out_valid), 1);
    chk("R3 stalled fin", int'(out_fin), 9);
    chk("R2 ins closed during slot", int'(ins_ready), 0);
    vt_col = 3'd6; slot_start = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
    @(negedge clk);
    chk("R9 R10 held fin", int'(out_fin), 9);
    chk("R9 R10 held sid", int'(out_sid), 1);
    chk("R9 held source", int'(out_from_b), 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R4 second offer fin", int'(out_fin), 7);
    chk("R11 second from b", int'(out_from_b), 1);
    @(negedge clk);
    chk("R5 done after b", int'(slot_done), 1);
    @(negedge clk);
    @(negedge clk);
    chk("R10 no extra sequence", int'(out_valid), 0);
    chk("R10 no extra done", int'(slot_done), 0);
    run_slot(4, 6);
    chk("R8 removed entries gone", rcnt, 0);

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule